// File: doc/BRIEF.md
# Converter Start-and-Read Sequencer

This block drives an external byte-wide analog-to-digital converter that has four active-low control pins: a select line, a start line, a read line and a completion flag driven by the converter. While enabled, it loops. It selects the part and pulses the start line for a programmed number of cycles. It then waits for the converter to pull its completion flag low, performs a timed read on the shared data bus, and hands the captured byte to the core side as a single-cycle valid strobe.

The completion flag is asynchronous. It passes through a two-flop synchroniser, and only a falling edge seen after the start pulse counts. A programmable watchdog limit bounds the wait. If no completion arrives in time, an error flag is raised and the sequencer starts a fresh conversion. A keep-selected mode holds the select line low across back-to-back conversions, so that only the start and read lines toggle.

All pin outputs come straight from flops. Their values are decoded from the next state, so the pins change together with the state register.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The select pin (`adc_sel_n`) is low for at least one full cycle before the start pin (`adc_start_n`) goes low.
- R2: The start pin stays low for exactly `start_cycles` clock cycles, with a value of 0 treated as 1, and then returns high.
- R3: After the start pulse, the block waits a variable time for the two-flop-synchronised completion flag (`adc_done_n`) to fall, and only then begins the read; any delay shorter than the timeout is accepted.
- R4: The select pin is low for at least one cycle before the read pin (`adc_read_n`) goes low. The read pin then stays low for exactly `access_cycles` cycles, with 0 treated as 1, and the bus is sampled at the end of the last of those cycles.
- R5: The read pin returns high at least one cycle before the select pin returns high.
- R6: The completion flag returning high after the read starts is ignored: it raises no error and produces no extra byte, so each completed conversion yields exactly one byte.
- R7: With `hold_select` = 1 and `run` = 1, the select pin stays low continuously across consecutive conversions.
- R8: If no completion edge is seen within `timeout_cycles`+1 cycles of waiting, `conv_error` goes high, no byte is presented, and a new conversion is started. `conv_error` stays high until the next byte is presented.
- R9: Each captured byte appears on `sample` together with a `sample_valid` pulse that lasts exactly one cycle, in conversion order.
- R10: After reset, the select, start and read pins are high, `sample_valid` is 0 and `conv_error` is 0.
- R11: When `run` is low, the block finishes any conversion in progress and then rests with all three control pins high and no further bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep performing conversions while high |
| hold_select | input | 1 | Keep select low between conversions |
| start_cycles | input | CNT_W | Start pulse width in cycles (0 means 1) |
| access_cycles | input | CNT_W | Read-low time before sampling (0 means 1) |
| timeout_cycles | input | TMO_W | Wait limit for the completion flag |
| adc_sel_n | output | 1 | Converter select, active low |
| adc_start_n | output | 1 | Conversion start, active low |
| adc_read_n | output | 1 | Read enable, active low |
| adc_done_n | input | 1 | Converter completion flag, active low, asynchronous |
| adc_bus | input | 8 | Converter data bus |
| sample | output | 8 | Last captured byte |
| sample_valid | output | 1 | One-cycle strobe for a new byte |
| conv_error | output | 1 | Completion timeout flag |

## Verification
A behavioural converter model in the bench answers after a different delay on every conversion. It drives an inverted byte until the read has been low for the full access time, so sampling one cycle early shows up as a corrupted byte. Its values include 0x00, 0xFF and scattered patterns.

Runs with short, zero (treated as one) and long pulse and access settings show apart an exact-width counter from an off-by-one one. A keep-selected run shows whether select is released between conversions. A suppressed-completion run separates a timeout restart from a hang. A run of dropping `run` in mid-stream shows whether the block completes its conversion and goes quiet.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned ADC_DW = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEL_WR = 3'd1,
        ST_WR_LO  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_SEL_RD = 3'd4,
        ST_RD_LO  = 3'd5,
        ST_REL    = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic sel_n;
        logic start_n;
        logic read_n;
    } pin_set_t;

    // Select is needed whenever the write or read exchange is in progress.
    function automatic logic needs_select(seq_state_t s);
        return (s == ST_SEL_WR) || (s == ST_WR_LO) || (s == ST_SEL_RD) ||
               (s == ST_RD_LO)  || (s == ST_REL);
    endfunction

    function automatic pin_set_t pins_for(seq_state_t s, logic keep_sel);
        pin_set_t p;
        p.sel_n   = !(needs_select(s) || keep_sel);
        p.start_n = (s != ST_WR_LO);
        p.read_n  = (s != ST_RD_LO);
        return p;
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic fall_pulse
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-1:0], async_n};
        end
    end

    // Edge taken between the last synchroniser stage and one extra history flop.
    assign fall_pulse = chain[STAGES] && !chain[STAGES-1];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    AST_TMR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired) else $error("timer left zero without load"); // R2

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned TMO_W   = 16,
    parameter int unsigned SYNC_ST = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             run,
    input  logic                             hold_select,
    input  logic [CNT_W-1:0]                 start_cycles,
    input  logic [CNT_W-1:0]                 access_cycles,
    input  logic [TMO_W-1:0]                 timeout_cycles,
    output logic                             adc_sel_n,
    output logic                             adc_start_n,
    output logic                             adc_read_n,
    input  logic                             adc_done_n,
    input  logic [adc_seq_pkg::ADC_DW-1:0]   adc_bus,
    output logic [adc_seq_pkg::ADC_DW-1:0]   sample,
    output logic                             sample_valid,
    output logic                             conv_error
);
    import adc_seq_pkg::*;

    localparam int unsigned TW = (TMO_W > CNT_W) ? TMO_W : CNT_W;

    seq_state_t state_q, state_d;
    pin_set_t   pins_q, pins_d;
    logic       done_fall;
    logic       done_seen_q;
    logic       tmr_load;
    logic       tmr_zero;
    logic [TW-1:0] tmr_val;
    logic       keep_sel;
    logic       capture;
    logic       timed_out;

    adc_seq_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_n    (adc_done_n),
        .fall_pulse (done_fall)
    );

    adc_seq_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    assign keep_sel  = hold_select && run;
    assign capture   = (state_q == ST_RD_LO) && tmr_zero;
    assign timed_out = (state_q == ST_WAIT) && !done_seen_q && tmr_zero;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (run) state_d = ST_SEL_WR;
            ST_SEL_WR: state_d = ST_WR_LO;
            ST_WR_LO:  if (tmr_zero) state_d = ST_WAIT;
            ST_WAIT: begin
                if (done_seen_q)   state_d = ST_SEL_RD;
                else if (tmr_zero) state_d = ST_IDLE;
            end
            ST_SEL_RD: state_d = ST_RD_LO;
            ST_RD_LO:  if (tmr_zero) state_d = ST_REL;
            ST_REL:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Timer reload on entry to each timed state.
    always_comb begin
        tmr_load = (state_d != state_q) &&
                   ((state_d == ST_WR_LO) || (state_d == ST_RD_LO) || (state_d == ST_WAIT));
        unique case (state_d)
            ST_WR_LO: tmr_val = (start_cycles == '0)  ? '0 : TW'(start_cycles - 1'b1);
            ST_RD_LO: tmr_val = (access_cycles == '0) ? '0 : TW'(access_cycles - 1'b1);
            default:  tmr_val = TW'(timeout_cycles);
        endcase
    end

    assign pins_d = pins_for(state_d, keep_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            pins_q       <= '{sel_n: 1'b1, start_n: 1'b1, read_n: 1'b1};
            done_seen_q  <= 1'b0;
            sample       <= '0;
            sample_valid <= 1'b0;
            conv_error   <= 1'b0;
        end else begin
            state_q      <= state_d;
            pins_q       <= pins_d;
            sample_valid <= capture;
            if (state_d == ST_WR_LO && state_q != ST_WR_LO) begin
                done_seen_q <= 1'b0;
            end else if (done_fall && (state_q == ST_WAIT || state_q == ST_WR_LO)) begin
                done_seen_q <= 1'b1;
            end
            if (capture) begin
                sample     <= adc_bus;
                conv_error <= 1'b0;
            end else if (timed_out) begin
                conv_error <= 1'b1;
            end
        end
    end

    assign adc_sel_n   = pins_q.sel_n;
    assign adc_start_n = pins_q.start_n;
    assign adc_read_n  = pins_q.read_n;

    AST_START_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        !adc_start_n |-> !adc_sel_n) else $error("start low without select"); // R1
    AST_SEL_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_start_n) |-> !$past(adc_sel_n)) else $error("select not early"); // R1
    AST_START_WIDTH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_start_n) |-> $past(tmr_zero)) else $error("start released early"); // R2
    AST_SEL_BEFORE_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_read_n) |-> !$past(adc_sel_n)) else $error("select not before read"); // R4
    AST_NO_START_READ_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(!adc_start_n && !adc_read_n)) else $error("start and read both low"); // R4
    AST_READ_RELEASE_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_sel_n) |-> (adc_read_n && $past(adc_read_n))) else $error("select dropped during read"); // R5
    AST_KEEP_SELECT: assert property (@(posedge clk) disable iff (rst)
        (keep_sel && $past(keep_sel) && !$past(adc_sel_n)) |-> !adc_sel_n) else $error("select released in hold mode"); // R7
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid) else $error("valid longer than a cycle"); // R9
    AST_NO_VALID_ON_ERROR: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_error) |-> !sample_valid) else $error("byte with timeout"); // R8

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;

    localparam int CNT_W = 8;
    localparam int TMO_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic hold_select = 1'b0;
    logic [CNT_W-1:0] start_cycles = 8'd3;
    logic [CNT_W-1:0] access_cycles = 8'd2;
    logic [TMO_W-1:0] timeout_cycles = 16'd40;
    logic adc_sel_n, adc_start_n, adc_read_n;
    logic adc_done_n;
    wire  [7:0] adc_bus;
    logic [7:0] sample;
    logic sample_valid, conv_error;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_dut (
        .clk(clk), .rst(rst), .run(run), .hold_select(hold_select),
        .start_cycles(start_cycles), .access_cycles(access_cycles),
        .timeout_cycles(timeout_cycles),
        .adc_sel_n(adc_sel_n), .adc_start_n(adc_start_n), .adc_read_n(adc_read_n),
        .adc_done_n(adc_done_n), .adc_bus(adc_bus),
        .sample(sample), .sample_valid(sample_valid), .conv_error(conv_error)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Scoreboard queue filled by the converter model.
    logic [7:0] exp_q[$];
    task automatic push_expect(input logic [7:0] v);
        exp_q.push_back(v);
    endtask

    // Behavioural converter
    bit   suppress = 1'b0;
    int   conv_seq = 0;
    int   conv_cnt = 0;
    int   wcnt = 0, rcnt = 0, dly = 0;
    bit   busy = 1'b0;
    int   sel_rises = 0;
    logic prev_start = 1'b1, prev_read = 1'b1, prev_sel = 1'b1;
    logic [7:0] held_val = 8'h00;
    logic [7:0] bus_val = 8'h00;
    logic bus_en = 1'b0;

    assign adc_bus = bus_en ? bus_val : 8'hzz;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    initial adc_done_n = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            wcnt = 0; rcnt = 0; busy = 1'b0;
            adc_done_n = 1'b1; bus_en = 1'b0;
        end else begin
            if (!adc_start_n) begin
                if (prev_start) chk(!prev_sel, "R1", prev_sel, 0);
                wcnt++;
            end else if (!prev_start) begin
                chk(wcnt == eff(start_cycles), "R2", wcnt, eff(start_cycles));
                wcnt = 0;
                adc_done_n = 1'b1;
                busy = 1'b1;
                dly = 2 + (conv_seq * 5) % 11;
            end
            if (busy) begin
                if (dly == 0) begin
                    busy = 1'b0;
                    if (!suppress) begin
                        held_val = (conv_seq == 0) ? 8'h00 :
                                   (conv_seq == 1) ? 8'hFF : 8'((conv_seq * 53 + 17) % 256);
                        conv_seq++;
                        conv_cnt++;
                        push_expect(held_val);
                        adc_done_n = 1'b0;
                    end
                end else begin
                    dly--;
                end
            end
            if (!adc_read_n) begin
                if (prev_read) chk(!prev_sel, "R4", prev_sel, 0);
                rcnt++;
                adc_done_n = 1'b1;
            end else if (!prev_read) begin
                chk(rcnt == eff(access_cycles), "R4", rcnt, eff(access_cycles));
                rcnt = 0;
            end
            bus_en  = !adc_sel_n && !adc_read_n;
            bus_val = (rcnt >= eff(access_cycles)) ? held_val : ~held_val;
            if (adc_sel_n && !prev_sel) begin
                sel_rises++;
                chk(prev_read == 1'b1, "R5", prev_read, 1);
            end
        end
        prev_start = adc_start_n;
        prev_read  = adc_read_n;
        prev_sel   = adc_sel_n;
    end

    // Monitor
    int valid_cnt = 0;
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (!rst && sample_valid) begin
            valid_cnt++;
            chk(!prev_valid, "R9", prev_valid, 0);
            chk(!conv_error, "R8", conv_error, 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", sample, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(sample == e, "R9", sample, e);
            end
        end
        prev_valid = sample_valid;
    end

    task automatic wait_bytes(input int n, input string req);
        int target;
        int guard;
        target = valid_cnt + n;
        guard = 0;
        while (valid_cnt < target && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(valid_cnt >= target, req, valid_cnt, target);
    endtask

    task automatic stop_and_idle();
        int vc;
        @(negedge clk);
        run = 1'b0;
        repeat (120) @(negedge clk);
        vc = valid_cnt;
        repeat (50) @(negedge clk);
        chk(adc_sel_n && adc_start_n && adc_read_n, "R11",
            {adc_sel_n, adc_start_n, adc_read_n}, 7);
        chk(valid_cnt == vc, "R11", valid_cnt, vc);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int guard;
        int vc;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(adc_sel_n && adc_start_n && adc_read_n, "R10",
            {adc_sel_n, adc_start_n, adc_read_n}, 7);
        chk(!sample_valid && !conv_error, "R10", {sample_valid, conv_error}, 0);

        // Plain conversions with moderate widths; variable delays (R3)
        start_cycles = 8'd3; access_cycles = 8'd2;
        run = 1'b1;
        wait_bytes(4, "R3");
        chk(!conv_error, "R6", conv_error, 0);
        stop_and_idle();

        // Zero settings behave as one cycle
        start_cycles = 8'd0; access_cycles = 8'd0;
        run = 1'b1;
        wait_bytes(3, "R2");
        stop_and_idle();

        // Long pulse and access time
        start_cycles = 8'd7; access_cycles = 8'd5;
        run = 1'b1;
        wait_bytes(3, "R4");
        stop_and_idle();

        // Held select across conversions
        start_cycles = 8'd2; access_cycles = 8'd3;
        hold_select = 1'b1;
        @(negedge clk);
        run = 1'b1;
        repeat (3) @(negedge clk);
        sel_rises = 0;
        wait_bytes(4, "R7");
        chk(sel_rises == 0, "R7", sel_rises, 0);
        chk(!adc_sel_n, "R7", adc_sel_n, 0);
        stop_and_idle();
        hold_select = 1'b0;

        // Completion never arrives: timeout, retry, recover
        suppress = 1'b1;
        timeout_cycles = 16'd30;
        vc = valid_cnt;
        run = 1'b1;
        guard = 0;
        while (!conv_error && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk(conv_error, "R8", conv_error, 1);
        repeat (150) @(negedge clk);
        chk(conv_error, "R8", conv_error, 1);
        chk(valid_cnt == vc, "R8", valid_cnt, vc);
        suppress = 1'b0;
        wait_bytes(2, "R8");
        @(negedge clk);
        chk(!conv_error, "R8", conv_error, 0);
        stop_and_idle();

        chk(conv_cnt == valid_cnt, "R6", valid_cnt, conv_cnt);
        chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            report();
        end
    end

endmodule